// File: doc/BRIEF.md
# Dual-Bank Mixed-Trigger Interrupt Controller

This block collects 64 interrupt input lines into two 32-bit banks and folds them into one interrupt request for a single processor. Each bank holds three pieces of state: a latched-event word, an enable mask and a sampled copy of the live input levels. A fixed, per-bank set of lines is treated as level-sensitive. Every other line is edge-sensitive: a rising edge latches an event bit that software must acknowledge.

Software reaches the block through a single-cycle register port with a write strobe, a read strobe, a 12-bit address and 32-bit data. Through this port it reads the event, mask and level words, writes the mask, and acknowledges events through a write-one-to-clear word. All data crossing the port is byte-reversed. The request output is registered, so it follows the bank state with one clock of latency.

Top module: `irq_dual_bank_ctrl`

## Requirements
- R1: Input line n lands in bank 1 when bit 5 of n is 0 and in bank 0 when bit 5 of n is 1. In either case it occupies bit n[4:0] of that bank.
- R2: For a line that is not level-sensitive, a rising edge (the line is high and was low on the previous clock) sets its event bit. The bit stays set after the line falls and is removed only by an acknowledge.
- R3: A level-sensitive line never sets its event bit. It contributes to the request through its level bit alone, so the request drops once the line falls.
- R4: Each level bit holds the value of its input line as sampled at the previous clock edge.
- R5: A bank is pending when ((event OR (level AND level-sensitive set)) AND mask) is non-zero. irq_o equals the OR of both banks' pending state one clock earlier.
- R6: A write to the acknowledge word clears the event bits that are written as 1, except bits in the level-sensitive set. When a rising edge and an acknowledge hit the same bit in the same cycle, the bit ends up set.
- R7: Bank 0 decodes at addresses 0x010–0x01F and bank 1 at 0x020–0x02F. Within a bank, address[3:0] selects the word: 0x0 is the event word (read only), 0x4 the mask (read/write), 0x8 the acknowledge word (write only) and 0xC the level word (read only). Any other address or offset reads as zero, and writes to it change nothing.
- R8: Bus data is byte-reversed in both directions: bus byte 3 (bits 31:24) corresponds to internal byte 0 (bits 7:0), and so on. For example, internal value 0x00000020 appears on the bus as 0x20000000.
- R9: After reset, every event, mask and level word and irq_o read as zero. Bank 0 has no level-sensitive lines and bank 1 has level-sensitive set 0x1FF00000, which covers input lines 20 to 28.
- R10: Read data appears on rdata in the cycle after rd_en is sampled and holds until the next read. A write takes effect at the clock edge that samples wr_en, so a read in the same cycle returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_lines | input | 64 | Interrupt input lines, indexed by input number |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Register byte address |
| wdata | input | 32 | Write data (bus byte order) |
| rdata | output | 32 | Registered read data (bus byte order) |
| irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
The bench builds the block with its default parameters: two 32-bit banks, no level-sensitive lines in bank 0, and level-sensitive set 0x1FF00000 in bank 1. With these values the reversed mapping of input numbers to banks can be observed, and lines 20 to 28 can be driven to compare acknowledge and request behaviour against edge lines in the same bank. The byte reversal is checked against literal bus values, and the out-of-range decode is probed below 0x010 and above 0x02F. Random line toggling, mixed with writes and reads to valid and invalid addresses, exercises collisions between rising edges and acknowledges.

// File: rtl/irq_dual_pkg.sv
// Shared constants and helpers for the dual-bank interrupt controller.
// Assumes bus data width equals bank width and is a whole number of bytes.
package irq_dual_pkg;
    localparam int BANK_W    = 32;
    localparam int NUM_BANKS = 2;
    localparam int ADDR_W    = 12;

    // Word offsets inside one bank window (address[3:0]).
    localparam logic [3:0] OFS_EVT = 4'h0;
    localparam logic [3:0] OFS_MSK = 4'h4;
    localparam logic [3:0] OFS_ACK = 4'h8;
    localparam logic [3:0] OFS_LVL = 4'hC;

    // Address of the first bank window; each window spans 16 bytes.
    localparam logic [ADDR_W-1:0] BANK_BASE = 12'h010;

    // Reverses byte order of a BANK_W-bit word.
    function automatic logic [BANK_W-1:0] swap_bytes(input logic [BANK_W-1:0] v);
        logic [BANK_W-1:0] r;
        for (int i = 0; i < BANK_W / 8; i++) begin
            r[i*8 +: 8] = v[BANK_W-8-i*8 +: 8];
        end
        return r;
    endfunction
endpackage

// File: rtl/irq_bank.sv
// One interrupt bank: samples its lines, latches rising edges of
// edge-sensitive lines, holds the enable mask, and reports pending state.
// Assumes lines are already synchronous to clk; LVL_TRIG is fixed at build.
module irq_bank #(
    parameter int            W        = 32,
    parameter logic [W-1:0]  LVL_TRIG = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] line_in,
    input  logic         mask_we,
    input  logic         ack_we,
    input  logic [W-1:0] wr_val,
    output logic [W-1:0] events_q,
    output logic [W-1:0] mask_q,
    output logic [W-1:0] levels_q,
    output logic         pending
);
    logic [W-1:0] rise;
    logic [W-1:0] ack_bits;
    logic [W-1:0] events_nxt;

    // Edge detect, acknowledge filter and set-wins event update.
    always_comb begin
        rise       = line_in & ~levels_q & ~LVL_TRIG;
        ack_bits   = ack_we ? (wr_val & ~LVL_TRIG) : '0;
        events_nxt = (events_q & ~ack_bits) | rise;
        pending    = |((events_q | (levels_q & LVL_TRIG)) & mask_q);
    end

    // State registers: level sample, event latch, mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            levels_q <= '0;
            events_q <= '0;
            mask_q   <= '0;
        end else begin
            levels_q <= line_in;
            events_q <= events_nxt;
            if (mask_we) begin
                mask_q <= wr_val;
            end
        end
    end

    // R3: level-sensitive lines never hold an event bit.
    assert_lt_no_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((events_q & LVL_TRIG) == '0));

    // R2: a rising edge on an edge line is latched at the next edge.
    assert_rise_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|(line_in & ~levels_q & ~LVL_TRIG)) |=>
        ((events_q & $past(line_in & ~levels_q & ~LVL_TRIG)) ==
         $past(line_in & ~levels_q & ~LVL_TRIG)));

    // R2: without an acknowledge no event bit is lost.
    assert_event_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_we |=> ((events_q & $past(events_q)) == $past(events_q)));

    // R6: an acknowledge leaves bits written as zero untouched.
    assert_ack_scope_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_we |=> ((events_q & $past(events_q & ~wr_val)) == $past(events_q & ~wr_val)));
endmodule

// File: rtl/irq_regif.sv
// Register port decode: maps the address to a bank and word, byte-reverses
// data in both directions, and registers read data for one-cycle latency.
// Assumes single-cycle accesses; unmatched addresses read zero.
module irq_regif
    import irq_dual_pkg::*;
#(
    parameter int W  = 32,
    parameter int NB = 2,
    parameter int AW = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [AW-1:0]        addr,
    input  logic [W-1:0]         wdata,
    input  logic [NB-1:0][W-1:0] evt_all,
    input  logic [NB-1:0][W-1:0] msk_all,
    input  logic [NB-1:0][W-1:0] lvl_all,
    output logic [NB-1:0]        msk_we,
    output logic [NB-1:0]        ack_we,
    output logic [W-1:0]         wr_val,
    output logic [W-1:0]         rdata
);
    localparam int IDX_W = AW - 4;

    logic [AW-1:0]    rel;
    logic [IDX_W-1:0] idx;
    logic [3:0]       ofs;
    logic [NB-1:0]    hit;
    logic [W-1:0]     rd_word;

    // Bank index from address offset relative to the first window.
    always_comb begin
        rel    = addr - AW'(BANK_BASE);
        idx    = rel[AW-1:4];
        ofs    = addr[3:0];
        wr_val = swap_bytes(wdata);
    end

    // Per-bank hit and write strobes.
    for (genvar b = 0; b < NB; b++) begin : g_dec
        assign hit[b]    = (idx == IDX_W'(b));
        assign msk_we[b] = wr_en & hit[b] & (ofs == OFS_MSK);
        assign ack_we[b] = wr_en & hit[b] & (ofs == OFS_ACK);
    end

    // Read word select for the hit bank and offset.
    always_comb begin
        rd_word = '0;
        for (int b = 0; b < NB; b++) begin
            if (hit[b]) begin
                case (ofs)
                    OFS_EVT: rd_word = evt_all[b];
                    OFS_MSK: rd_word = msk_all[b];
                    OFS_LVL: rd_word = lvl_all[b];
                    default: rd_word = '0;
                endcase
            end
        end
    end

    // Read data register, updated only on an accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= swap_bytes(rd_word);
        end
    end

    // R7: a read outside every bank window returns zero.
    assert_oob_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (hit == '0)) |=> (rdata == '0));

    // R7: at most one word of one bank is written per access.
    assert_single_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({msk_we, ack_we}));

    // R10: read data holds while no read is accepted.
    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

// File: rtl/irq_dual_bank_ctrl.sv
// Top of the dual-bank interrupt controller: routes input lines to banks
// (low half of the inputs to the upper bank), joins the register port and
// registers the combined request. Assumes synchronous inputs, one processor.
module irq_dual_bank_ctrl
    import irq_dual_pkg::*;
#(
    parameter int BANK_W_P    = BANK_W,
    parameter int NUM_BANKS_P = NUM_BANKS,
    parameter int ADDR_W_P    = ADDR_W,
    parameter logic [NUM_BANKS_P-1:0][BANK_W_P-1:0] LVL_TRIG = {32'h1FF0_0000, 32'h0000_0000}
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_BANKS_P*BANK_W_P-1:0]     irq_lines,
    input  logic                                wr_en,
    input  logic                                rd_en,
    input  logic [ADDR_W_P-1:0]                 addr,
    input  logic [BANK_W_P-1:0]                 wdata,
    output logic [BANK_W_P-1:0]                 rdata,
    output logic                                irq_o
);
    localparam int WIN_END = 16 * (NUM_BANKS_P + 1);

    logic [NUM_BANKS_P-1:0][BANK_W_P-1:0] evt_all;
    logic [NUM_BANKS_P-1:0][BANK_W_P-1:0] msk_all;
    logic [NUM_BANKS_P-1:0][BANK_W_P-1:0] lvl_all;
    logic [NUM_BANKS_P-1:0]               pend_vec;
    logic [NUM_BANKS_P-1:0]               msk_we;
    logic [NUM_BANKS_P-1:0]               ack_we;
    logic [BANK_W_P-1:0]                  wr_val;

    irq_regif #(
        .W  (BANK_W_P),
        .NB (NUM_BANKS_P),
        .AW (ADDR_W_P)
    ) u_regif (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .evt_all (evt_all),
        .msk_all (msk_all),
        .lvl_all (lvl_all),
        .msk_we  (msk_we),
        .ack_we  (ack_we),
        .wr_val  (wr_val),
        .rdata   (rdata)
    );

    // Bank b takes input group (NUM_BANKS_P-1-b): reversed line mapping.
    for (genvar b = 0; b < NUM_BANKS_P; b++) begin : g_bank
        irq_bank #(
            .W        (BANK_W_P),
            .LVL_TRIG (LVL_TRIG[b])
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .line_in  (irq_lines[(NUM_BANKS_P-1-b)*BANK_W_P +: BANK_W_P]),
            .mask_we  (msk_we[b]),
            .ack_we   (ack_we[b]),
            .wr_val   (wr_val),
            .events_q (evt_all[b]),
            .mask_q   (msk_all[b]),
            .levels_q (lvl_all[b]),
            .pending  (pend_vec[b])
        );
    end

    // Registered request: OR of all banks' pending state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= |pend_vec;
        end
    end

    // R5: request follows combined pending state with one clock latency.
    assert_irq_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|pend_vec)));

    // R7: a write outside every bank window leaves all masks unchanged.
    assert_oob_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ((addr < ADDR_W_P'(BANK_BASE)) || (addr >= ADDR_W_P'(WIN_END))))
        |=> $stable(msk_all));
endmodule

// File: tb/tb_irq_dual_bank_ctrl.sv
`timescale 1ns/1ps
module tb_irq_dual_bank_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_lines = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_o;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] m_ev [2];
    logic [31:0] m_mk [2];
    logic [31:0] m_lv [2];
    logic [63:0] cur = '0;

    always #2 clk = ~clk;

    irq_dual_bank_ctrl dut (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
    );

    function automatic logic [31:0] bsw(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    function automatic logic [31:0] lt_of(input int b);
        return (b == 1) ? 32'h1FF0_0000 : 32'h0;
    endfunction

    function automatic logic pend_all();
        logic p = 1'b0;
        for (int b = 0; b < 2; b++)
            p |= |((m_ev[b] | (m_lv[b] & lt_of(b))) & m_mk[b]);
        return p;
    endfunction

    function automatic logic [31:0] model_read(input logic [11:0] a);
        int b;
        if (a < 12'h010 || a > 12'h02F) return '0;
        b = (a[5:4] == 2'd1) ? 0 : 1;
        case (a[3:0])
            4'h0: return m_ev[b];
            4'h4: return m_mk[b];
            4'hC: return m_lv[b];
            default: return '0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: drive at negedge, update model, compare at next negedge.
    task automatic step(input logic [63:0] ln, input logic we, input logic re,
                        input logic [11:0] a, input logic [31:0] d, input string tag);
        logic        e_irq;
        logic [31:0] e_rd;
        irq_lines = ln; wr_en = we; rd_en = re; addr = a; wdata = d;
        e_irq = pend_all();
        e_rd  = bsw(model_read(a));
        for (int b = 0; b < 2; b++) begin
            logic [31:0] in_b, rise, clr;
            in_b = (b == 0) ? ln[63:32] : ln[31:0];
            rise = in_b & ~m_lv[b] & ~lt_of(b);
            clr  = '0;
            if (we && a >= 12'h010 && a <= 12'h02F && ((a[5:4] == 2'd1) == (b == 0))) begin
                if (a[3:0] == 4'h4) m_mk[b] = bsw(d);
                if (a[3:0] == 4'h8) clr = bsw(d) & ~lt_of(b);
            end
            m_ev[b] = (m_ev[b] & ~clr) | rise;
            m_lv[b] = in_b;
        end
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R5 irq", {31'd0, irq_o}, {31'd0, e_irq});
        if (re) chk(tag, rdata, e_rd);
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        step(cur, 1'b0, 1'b1, a, '0, tag);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        step(cur, 1'b1, 1'b0, a, d, "R7");
    endtask

    task automatic idle();
        step(cur, 1'b0, 1'b0, '0, '0, "");
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    function automatic logic [11:0] pick_addr(input int k);
        case (k)
            0: return 12'h010; 1: return 12'h014; 2: return 12'h018; 3: return 12'h01C;
            4: return 12'h020; 5: return 12'h024; 6: return 12'h028; 7: return 12'h02C;
            8: return 12'h034; default: return 12'h004;
        endcase
    endfunction

    initial begin
        #(200000 * 4);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        for (int b = 0; b < 2; b++) begin m_ev[b] = '0; m_mk[b] = '0; m_lv[b] = '0; end
        void'($urandom(32'd20250611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        chk("R9 irq after reset", {31'd0, irq_o}, 32'd0);
        rd(12'h010, "R9 bank0 event"); rd(12'h014, "R9 bank0 mask"); rd(12'h01C, "R9 bank0 level");
        rd(12'h020, "R9 bank1 event"); rd(12'h024, "R9 bank1 mask"); rd(12'h02C, "R9 bank1 level");

        // R8: byte reversal of mask write and read-back
        wr(12'h024, 32'h2000_0000);
        rd(12'h024, "R8 mask readback");
        chk("R8 literal bus value", rdata, 32'h2000_0000);

        // R1/R2/R5: input 5 -> bank1 bit5, request one clock after latch
        cur[5] = 1'b1; idle();
        chk("R5 irq not yet", {31'd0, irq_o}, 32'd0);
        idle();
        chk("R5 irq asserted", {31'd0, irq_o}, 32'd1);
        rd(12'h020, "R1 bank1 event");
        chk("R1 input5 bank1 bit5", rdata, 32'h2000_0000);
        rd(12'h02C, "R4 bank1 level");
        chk("R4 level bit5", rdata, 32'h2000_0000);
        cur[5] = 1'b0; idle(); idle();
        rd(12'h020, "R2 event held");
        chk("R2 event after fall", rdata, 32'h2000_0000);
        chk("R2 irq held", {31'd0, irq_o}, 32'd1);

        // R6: acknowledge clears edge event, request drops
        wr(12'h028, 32'h2000_0000); idle(); idle();
        rd(12'h020, "R6 ack cleared");
        chk("R6 event zero", rdata, 32'h0);
        chk("R6 irq low", {31'd0, irq_o}, 32'd0);

        // R1: input 40 -> bank0 bit8
        cur[40] = 1'b1; idle();
        rd(12'h010, "R1 bank0 event");
        chk("R1 input40 bank0 bit8", rdata, 32'h0001_0000);
        chk("R1 masked no irq", {31'd0, irq_o}, 32'd0);

        // R3: level-sensitive input 22
        wr(12'h024, 32'h2000_4000);
        cur[22] = 1'b1; idle(); idle();
        chk("R3 level irq", {31'd0, irq_o}, 32'd1);
        rd(12'h020, "R3 no event");
        chk("R3 event bit22 clear", rdata, 32'h0);
        rd(12'h02C, "R3 level word");
        chk("R3 level bit22", rdata, 32'h0000_4000);
        wr(12'h028, 32'h0000_4000); idle();
        chk("R6 ack ignores level line", {31'd0, irq_o}, 32'd1);
        cur[22] = 1'b0; idle(); idle();
        chk("R3 irq drops with line", {31'd0, irq_o}, 32'd0);

        // R6: rise and acknowledge on the same bit, same cycle -> set wins
        cur[7] = 1'b1;
        step(cur, 1'b1, 1'b0, 12'h028, 32'h8000_0000, "R6");
        rd(12'h020, "R6 set wins");
        chk("R6 bit7 kept", rdata, 32'h8000_0000);

        // R7: out-of-range and unused offsets
        wr(12'h034, 32'hFFFF_FFFF); wr(12'h004, 32'hFFFF_FFFF);
        wr(12'h010, 32'hFFFF_FFFF); wr(12'h01C, 32'hFFFF_FFFF);
        rd(12'h034, "R7 oob read"); chk("R7 oob zero", rdata, 32'h0);
        rd(12'h004, "R7 low read"); chk("R7 low zero", rdata, 32'h0);
        rd(12'h018, "R7 ack read"); chk("R7 ack reads zero", rdata, 32'h0);
        rd(12'h014, "R7 bank0 mask unchanged"); chk("R7 bank0 mask zero", rdata, 32'h0);
        rd(12'h024, "R7 bank1 mask unchanged"); chk("R7 bank1 mask", rdata, 32'h2000_4000);

        // R10: read in the same cycle as a write returns old value
        step(cur, 1'b1, 1'b1, 12'h014, 32'h1234_5678, "R10 old value");
        chk("R10 old mask", rdata, 32'h0);
        rd(12'h014, "R10 new value");
        chk("R10 new mask", rdata, 32'h1234_5678);
        idle();
        chk("R10 rdata holds", rdata, 32'h1234_5678);

        // Random phase
        for (int i = 0; i < 3000; i++) begin
            logic [63:0] flip;
            logic [11:0] a;
            logic [31:0] d;
            int kind;
            flip = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            cur ^= flip;
            a = pick_addr($urandom_range(0, 9));
            kind = $urandom_range(0, 3);
            d = $urandom;
            if (a[3:0] == 4'h8) d = d | $urandom;
            step(cur, kind >= 2, kind[0], a, d, "R7 random read");
        end

        summary();
        $finish;
    end
endmodule